// File: doc/BRIEF.md
# Four-Channel Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analogue-to-digital converter shared between four multiplexed inputs. When a start request is accepted it captures the requested channel and the prescale factor. It drives the input multiplexer select and steps through ten bit trials from the most significant bit downwards. On each trial it presents a trial code to the external trial DAC and reads back a single comparator decision. At the end it publishes a 10-bit result and a done flag.

The conversion clock is a single-cycle enable derived from the system clock by a programmable prescaler. There is no gated clock. Every conversion lasts a fixed frame of twelve conversion-clock periods:

- one period for the multiplexer to settle,
- ten bit-trial periods,
- one period to load the result register.

There is no sample-and-hold phase, so the trials run on the live multiplexer input. The comparator, the trial DAC and the analogue multiplexer are outside this block.

Top module: `sar_mux_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `result` and `mux_sel` are all 0.
- R2: A start accepted while idle latches `chan_req` into `mux_sel` on that clock edge. `mux_sel` then holds that value for the whole conversion, whatever `chan_req` does.
- R3: A start request while `busy` is high is ignored. The running conversion keeps its channel, its end time and its result.
- R4: With effective prescale factor E, `done` rises exactly 12·E clock edges after the accepting edge. On that same edge `busy` falls.
- R5: When the comparator reports (selected input ≥ `trial_code`), `result` equals the selected input's 10-bit value (0..1023). On each trial the bit under trial is kept if `cmp_ge` is 1 and cleared if it is 0.
- R6: A `div_factor` of 0 behaves as 1, giving a 12-cycle conversion.
- R7: Bit trials run MSB first. `trial_code` is 0 during the settle period, and equals 512 (only bit 9 set) throughout the first trial period, which begins E edges after acceptance.
- R8: `done` and `result` hold their values after completion until the next accepted start. On that start edge `done` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, accepted only while idle |
| chan_req | input | 2 | Requested input channel |
| div_factor | input | 8 | Prescale factor (0 treated as 1) |
| cmp_ge | input | 1 | Comparator: selected input ≥ trial_code |
| mux_sel | output | 2 | Analogue multiplexer select |
| trial_code | output | 10 | Code to the trial DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Result valid since last completion |
| result | output | 10 | Converted value |

## Verification
The most likely symptoms of a wrong internal state are these:

- A corrupted trial register or bit index shows up as a wrong `result` at the end of that conversion. An ideal comparator makes the expected value simply the analogue input code.
- A prescaler miscount shifts the rising edge of `done` away from 12·E edges. The bench times it to the exact cycle.
- A channel latch that follows `chan_req` makes the comparator read a different input within one conversion-clock period. The other channels are given deliberately different values, so this also lands in `result`.

// File: rtl/sar_pkg.sv
// Shared types and constants for the multiplexed SAR conversion sequencer.
// Assumes a 10-bit converter with a 12-period conversion frame.
package sar_pkg;
    localparam int SAR_RES_W  = 10;
    localparam int SAR_OVH    = 2;
    localparam int SAR_FRAME  = SAR_RES_W + SAR_OVH;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_LOAD   = 2'd3
    } sar_phase_e;
endpackage

// File: rtl/sar_prescaler.sv
// Conversion-clock prescaler: emits a one-cycle enable tick every E system
// clocks while running, where E is the factor latched at restart (0 -> 1).
// Assumes restart is asserted exactly on the accepting edge of a conversion.
module sar_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // Terminal count: factor minus one, with a zero factor acting as one.
    always_comb last = (div_q == '0) ? '0 : div_q - 1'b1;

    // Tick on the terminal count while a conversion is running.
    always_comb tick = run && (cnt == last);

    // Latch the factor on restart and count system clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (restart) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last));
endmodule

// File: rtl/sar_chan_hold.sv
// Channel latch: captures the requested channel on an accepted start and
// drives the multiplexer select from it. Assumes capture is one cycle wide.
module sar_chan_hold #(
    parameter int N_CH = 4,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [CH_W-1:0] chan_in,
    output logic [CH_W-1:0] sel
);
    // Hold the captured channel until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel <= '0;
        else if (capture) sel <= chan_in;
    end
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation engine: walks settle, ten bit trials (MSB first)
// and a result load, advancing one phase per conversion-clock tick.
// Assumes cmp_ge reflects the current trial code when a tick arrives.
module sar_engine
    import sar_pkg::*;
#(
    parameter int RES_W = SAR_RES_W,
    localparam int BIT_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             tick,
    input  logic             cmp_ge,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] result
);
    sar_phase_e       phase;
    logic [BIT_W-1:0] bidx;
    logic [RES_W-1:0] sar;

    // Busy whenever the phase machine is away from idle.
    always_comb busy = (phase != PH_IDLE);
    // The trial register is driven straight to the trial DAC.
    always_comb trial_code = sar;

    // Phase machine, trial register and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            bidx   <= '0;
            sar    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase <= PH_SETTLE;
                    sar   <= '0;
                    done  <= 1'b0;
                end
                PH_SETTLE: if (tick) begin
                    phase           <= PH_TRIAL;
                    bidx            <= BIT_W'(RES_W - 1);
                    sar[RES_W-1]    <= 1'b1;
                end
                PH_TRIAL: if (tick) begin
                    if (!cmp_ge) sar[bidx] <= 1'b0;
                    if (bidx == '0) begin
                        phase <= PH_LOAD;
                    end else begin
                        bidx           <= bidx - 1'b1;
                        sar[bidx-1'b1] <= 1'b1;
                    end
                end
                PH_LOAD: if (tick) begin
                    phase  <= PH_IDLE;
                    result <= sar;
                    done   <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r7_trial_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRIAL && !tick) |-> sar[bidx]);
    a_r7_settle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETTLE) |-> (trial_code == '0));
    a_r4_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy)));
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |=> (done && $stable(result)));
endmodule

// File: rtl/sar_mux_sequencer.sv
// Top of the multiplexed SAR conversion sequencer: accepts a start while idle,
// latches channel and prescale factor, and runs a 12-tick conversion frame.
// Assumes comparator, trial DAC and analogue multiplexer sit outside.
module sar_mux_sequencer
    import sar_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int DIV_W = 8,
    parameter int RES_W = SAR_RES_W,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  chan_req,
    input  logic [DIV_W-1:0] div_factor,
    input  logic             cmp_ge,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] trial_code,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    logic accept;
    logic tick;

    // A start is taken only while no conversion is in progress.
    always_comb accept = start && !busy;

    sar_chan_hold #(.N_CH(N_CH)) u_chan (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .chan_in(chan_req), .sel(mux_sel)
    );

    sar_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
        .div_in(div_factor), .tick(tick)
    );

    sar_engine #(.RES_W(RES_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .accept(accept), .tick(tick),
        .cmp_ge(cmp_ge), .busy(busy), .done(done),
        .trial_code(trial_code), .result(result)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0 && mux_sel == '0));
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && mux_sel == $past(chan_req)));
    a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));
endmodule

// File: tb/tb_sar_mux_sequencer.sv
module tb_sar_mux_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] chan_req = '0;
    logic [7:0] div_factor = '0;
    logic       cmp_ge;
    logic [1:0] mux_sel;
    logic [9:0] trial_code;
    logic       busy, done;
    logic [9:0] result;
    logic [9:0] ain [4];

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    // Ideal comparator on the selected analogue input.
    always_comb cmp_ge = (ain[mux_sel] >= trial_code);

    sar_mux_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_req(chan_req),
        .div_factor(div_factor), .cmp_ge(cmp_ge), .mux_sel(mux_sel),
        .trial_code(trial_code), .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(1'b0, "watchdog", cycles, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // One conversion: optionally a late start with another channel (R3).
    task automatic convert(input int ch, input int d, input int val, input bit poke);
        int e = (d == 0) ? 1 : d;
        int n = 0;
        int t1 = -1;
        for (int c = 0; c < 4; c++)
            ain[c] = (c == ch) ? 10'(val) : 10'(val ^ (10'h155 + c));
        @(negedge clk);
        start = 1'b1; chan_req = 2'(ch); div_factor = 8'(d);
        @(negedge clk);
        start = 1'b0; chan_req = 2'(ch + 1);
        chk(busy == 1'b1 && done == 1'b0, "R8 done clear at accept", done, 0);
        chk(mux_sel == 2'(ch), "R2 channel captured", mux_sel, ch);
        chk(trial_code == 10'd0, "R7 settle code", trial_code, 0);
        while (!done && n < 12 * e + 8) begin
            @(negedge clk);
            n++;
            if (n == 3 && poke) begin start = 1'b1; chan_req = 2'(ch + 2); end
            if (n == 4) start = 1'b0;
            if (n == e) t1 = trial_code;
            if (busy && mux_sel != 2'(ch)) chk(1'b0, "R2 select held", mux_sel, ch);
        end
        start = 1'b0;
        chk(n == 12 * e, d == 0 ? "R6 zero factor length" : "R4 conversion length", n, 12 * e);
        chk(!busy, "R4 busy falls with done", busy, 0);
        chk(result == 10'(val), poke ? "R3 late start ignored" : "R5 result", result, val);
        if (val % 64 == 0) chk(t1 == 512, "R7 first trial code", t1, 512);
        if (val % 128 == 0) begin
            repeat (5) @(negedge clk);
            chk(done && result == 10'(val), "R8 result held", result, val);
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) ain[c] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && result == 0 && mux_sel == 0, "R1 reset state", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", busy, 0);
        for (int v = 0; v < 1024; v++) convert(v % 4, 1, v, 1'b0);
        for (int v = 0; v < 16; v++) convert(v % 4, 0, v * 67, 1'b0);
        for (int d = 2; d <= 7; d++)
            for (int v = 0; v < 24; v++) convert((v + d) % 4, d, (v * 43 + d * 11) % 1024, 1'b0);
        for (int v = 0; v < 8; v++) convert(v % 4, 2, 1023 - v * 97, 1'b1);
        convert(3, 3, 0, 1'b1);
        convert(1, 5, 1023, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule